// File: doc/BRIEF.md
# Power Domain Turn-On Sequencer

This block brings a chain of switchable power domains up one after another. Each domain is handled by its own sequencer. A sequencer first enables the domain's two rail switches. It then waits for both redundant power-good indications. Once power is confirmed it ungates the clock, drops isolation and releases reset, each on its own cycle. If the domain has SRAM, it then clears the selected SRAM power-down bits and waits for the matching acknowledge bits to fall.

Each wait has its own timeout. When a wait runs out, that domain stops in a sticky fault state and freezes its controls. The wrapper instantiates three sequencers:

- domain 0 is the memory-interface domain;
- domain 1 is the 2D engine domain;
- domain 2 is the 3D engine domain.

A domain starts only when the one before it has completed. A single start pulse therefore powers the whole chain. A fault anywhere stops the chain at that domain. All status inputs are assumed to be synchronous to `clk`.

Top module: `pds_chain`

## Requirements
- R1: While reset is asserted, and after it is released with no start, every domain's 12-bit control word is 0xF12. Bit 0 (reset_n) is 0, bit 1 (isolation) is 1, bits 2 and 3 (rail enables) are 0, bit 4 (clock-disable) is 1, bits 7:5 are 0 and bits 11:8 (SRAM power-down) are 1111. The done and fault outputs are low.
- R2: A start seen by an idle domain sets rail enable bit 2 on the next clock edge. Bit 3 is set one edge later. The power wait begins one edge after that.
- R3: A domain counts as powered only when both its primary and its secondary status inputs are high during the power wait. On the edge that sees this, clock-disable (bit 4) clears.
- R4: After clock-disable clears, isolation (bit 1) clears on the next edge. Reset_n (bit 0) goes high on the edge after that.
- R5: With a nonzero SRAM mask, the edge after reset release clears the power-down bits selected by the mask. The domain is done on the first edge that finds every acknowledge bit selected by the mask at 0. Acknowledge bits outside the mask are ignored.
- R6: With an SRAM mask of zero, the domain is done on the edge after reset release, and its power-down bits stay at 1111.
- R7: Each wait lasts at most TMO_CYC edges. If the condition is still false on the last of them, the domain enters fault. Its control word then stays frozen until reset.
- R8: Done and fault are never high together. Each stays high until reset.
- R9: A start input has no effect on a domain that is busy, done or faulted.
- R10: Domain i+1 starts on the edge after domain i reports done. After a fault in domain i, no later domain leaves its reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_start | input | 1 | Start pulse for the first domain |
| sta_pri | input | N_DOM | Primary power-good status, one bit per domain |
| sta_sec | input | N_DOM | Secondary power-good status, one bit per domain |
| sram_mask | input | 4*N_DOM | Per-domain SRAM bank select (zero skips the SRAM stage) |
| sram_ack | input | 4*N_DOM | Per-domain SRAM power-down acknowledge |
| dom_ctrl | output | 12*N_DOM | Per-domain control word (layout in R1) |
| dom_up | output | N_DOM | Domain finished its sequence |
| dom_fault | output | N_DOM | Domain timed out in a wait |
| chain_up | output | 1 | All domains are up |

## Verification
The assertions check the ordering invariants on every cycle:

- rail enable 2 is never on without rail enable 1;
- reset_n is never released while clock-disable or isolation is still set;
- the SRAM power-down bits never move before reset release;
- done and fault are never high together;
- a faulted domain's control word never changes;
- no domain starts before its predecessor is done.

The exact cycle on which each step happens can only be shown by the bench's scenarios, compared cycle by cycle against the reference model. The same holds for the exact timeout length, late-arriving status, acknowledge bits outside the mask, and starts that arrive while a domain is busy.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam int unsigned SRAM_W   = 4;
  localparam int unsigned B_RSTN   = 0;
  localparam int unsigned B_ISO    = 1;
  localparam int unsigned B_PON    = 2;
  localparam int unsigned B_PON2   = 3;
  localparam int unsigned B_CLKDIS = 4;
  localparam int unsigned PD_LSB   = 8;
  localparam int unsigned CTRL_W   = PD_LSB + SRAM_W;

  typedef enum logic [3:0] {
    PD_IDLE,
    PD_RAIL1,
    PD_RAIL2,
    PD_WAIT_PWR,
    PD_CLK_ON,
    PD_ISO_OFF,
    PD_RST_REL,
    PD_WAIT_ACK,
    PD_UP,
    PD_FAULT
  } pd_state_e;
endpackage

// File: rtl/pds_wait_timer.sv
module pds_wait_timer #(
  parameter int unsigned TMO_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int unsigned CNT_W = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    expired = run && (cnt_q == LAST);
    cnt_en  = restart || (run && !expired);
    cnt_d   = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/pds_domain_fsm.sv
module pds_domain_fsm
  import pds_pkg::*;
#(
  parameter int unsigned TMO_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sta_a,
  input  logic              sta_b,
  input  logic [SRAM_W-1:0] sram_mask,
  input  logic [SRAM_W-1:0] sram_ack,
  output logic [CTRL_W-1:0] ctrl,
  output logic              up,
  output logic              fault
);
  pd_state_e state_q, state_d;
  logic rstn_q, rstn_d, iso_q, iso_d, pon_q, pon_d, pon2_q, pon2_d, clkdis_q, clkdis_d;
  logic [SRAM_W-1:0] pd_q, pd_d;
  logic ctl_we, tmr_restart, tmr_run, tmr_expired, powered, ack_clear, has_sram;

  pds_wait_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .run     (tmr_run),
    .expired (tmr_expired)
  );

  always_comb begin
    powered   = sta_a && sta_b;
    has_sram  = |sram_mask;
    ack_clear = ~|(sram_ack & sram_mask);
    tmr_run   = (state_q == PD_WAIT_PWR) || (state_q == PD_WAIT_ACK);
  end

  always_comb begin
    state_d     = state_q;
    rstn_d      = rstn_q;
    iso_d       = iso_q;
    pon_d       = pon_q;
    pon2_d      = pon2_q;
    clkdis_d    = clkdis_q;
    pd_d        = pd_q;
    ctl_we      = 1'b0;
    tmr_restart = 1'b0;
    unique case (state_q)
      PD_IDLE: if (start) begin
        state_d = PD_RAIL1; pon_d = 1'b1; ctl_we = 1'b1;
      end
      PD_RAIL1: begin
        state_d = PD_RAIL2; pon2_d = 1'b1; ctl_we = 1'b1;
      end
      PD_RAIL2: begin
        state_d = PD_WAIT_PWR; tmr_restart = 1'b1;
      end
      PD_WAIT_PWR: begin
        if (powered) begin
          state_d = PD_CLK_ON; clkdis_d = 1'b0; ctl_we = 1'b1;
        end else if (tmr_expired) begin
          state_d = PD_FAULT;
        end
      end
      PD_CLK_ON: begin
        state_d = PD_ISO_OFF; iso_d = 1'b0; ctl_we = 1'b1;
      end
      PD_ISO_OFF: begin
        state_d = PD_RST_REL; rstn_d = 1'b1; ctl_we = 1'b1;
      end
      PD_RST_REL: begin
        if (has_sram) begin
          state_d = PD_WAIT_ACK; pd_d = pd_q & ~sram_mask;
          ctl_we = 1'b1; tmr_restart = 1'b1;
        end else begin
          state_d = PD_UP;
        end
      end
      PD_WAIT_ACK: begin
        if (ack_clear)        state_d = PD_UP;
        else if (tmr_expired) state_d = PD_FAULT;
      end
      PD_UP:    state_d = PD_UP;
      PD_FAULT: state_d = PD_FAULT;
      default:  state_d = PD_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PD_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstn_q   <= 1'b0;
      iso_q    <= 1'b1;
      pon_q    <= 1'b0;
      pon2_q   <= 1'b0;
      clkdis_q <= 1'b1;
      pd_q     <= '1;
    end else if (ctl_we) begin
      rstn_q   <= rstn_d;
      iso_q    <= iso_d;
      pon_q    <= pon_d;
      pon2_q   <= pon2_d;
      clkdis_q <= clkdis_d;
      pd_q     <= pd_d;
    end
  end

  always_comb begin
    ctrl                   = '0;
    ctrl[B_RSTN]           = rstn_q;
    ctrl[B_ISO]            = iso_q;
    ctrl[B_PON]            = pon_q;
    ctrl[B_PON2]           = pon2_q;
    ctrl[B_CLKDIS]         = clkdis_q;
    ctrl[PD_LSB +: SRAM_W] = pd_q;
    up                     = (state_q == PD_UP);
    fault                  = (state_q == PD_FAULT);
  end

  assert_rail_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pon2_q |-> pon_q);
  assert_dual_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clkdis_q) |-> $past(sta_a && sta_b));
  assert_release_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rstn_q |-> (!iso_q && !clkdis_q));
  assert_iso_after_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !iso_q |-> !clkdis_q);
  assert_sram_after_rst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_q != '1) |-> rstn_q);
  assert_skip_keeps_pd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up && (sram_mask == '0)) |-> (pd_q == '1));
  assert_fault_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && $past(fault)) |-> $stable(ctrl));
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && fault));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(up || fault) |-> (up || fault));
endmodule

// File: rtl/pds_chain.sv
module pds_chain
  import pds_pkg::*;
#(
  parameter int unsigned N_DOM   = 3,
  parameter int unsigned TMO_CYC = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      seq_start,
  input  logic [N_DOM-1:0]          sta_pri,
  input  logic [N_DOM-1:0]          sta_sec,
  input  logic [N_DOM*SRAM_W-1:0]   sram_mask,
  input  logic [N_DOM*SRAM_W-1:0]   sram_ack,
  output logic [N_DOM*CTRL_W-1:0]   dom_ctrl,
  output logic [N_DOM-1:0]          dom_up,
  output logic [N_DOM-1:0]          dom_fault,
  output logic                      chain_up
);
  logic [N_DOM-1:0] dom_start;

  for (genvar i = 0; i < N_DOM; i++) begin : g_dom
    if (i == 0) begin : g_first
      assign dom_start[i] = seq_start;
    end else begin : g_next
      assign dom_start[i] = dom_up[i-1];

      assert_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dom_ctrl[i*CTRL_W + B_PON] |-> dom_up[i-1]);
      assert_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dom_fault[i-1] |-> !dom_ctrl[i*CTRL_W + B_PON]);
    end

    pds_domain_fsm #(.TMO_CYC(TMO_CYC)) u_dom (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (dom_start[i]),
      .sta_a     (sta_pri[i]),
      .sta_b     (sta_sec[i]),
      .sram_mask (sram_mask[i*SRAM_W +: SRAM_W]),
      .sram_ack  (sram_ack[i*SRAM_W +: SRAM_W]),
      .ctrl      (dom_ctrl[i*CTRL_W +: CTRL_W]),
      .up        (dom_up[i]),
      .fault     (dom_fault[i])
    );
  end

  assign chain_up = &dom_up;
endmodule

// File: tb/pds_chain_test.sv
module pds_chain_test;
  localparam int ND = 3;
  localparam int T  = 20;

  logic clk, rst_n, seq_start;
  logic [ND-1:0] sta_pri, sta_sec;
  logic [4*ND-1:0] sram_mask, sram_ack;
  logic [12*ND-1:0] dom_ctrl;
  logic [ND-1:0] dom_up, dom_fault;
  logic chain_up;

  int vectors = 0, fails = 0, cycles = 0;
  bit finished = 0;

  // reference model state: 0 idle,1 rail1,2 rail2,3 power wait,4 clock on,
  // 5 isolation off,6 reset released,7 ack wait,8 up,9 fault
  int ph[ND];
  int cnt[ND];
  logic [11:0] ew[ND];

  pds_chain #(.N_DOM(ND), .TMO_CYC(T)) uut (
    .clk(clk), .rst_n(rst_n), .seq_start(seq_start),
    .sta_pri(sta_pri), .sta_sec(sta_sec),
    .sram_mask(sram_mask), .sram_ack(sram_ack),
    .dom_ctrl(dom_ctrl), .dom_up(dom_up), .dom_fault(dom_fault),
    .chain_up(chain_up)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic string tag_for(int p);
    case (p)
      0:       return "R1 R9";
      1, 2:    return "R2";
      3:       return "R3";
      4, 5, 6: return "R4";
      7:       return "R5";
      8:       return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic model_step(int d);
    bit st;
    logic [3:0] m, a;
    st = (d == 0) ? seq_start : (ph[d-1] == 8);
    m  = sram_mask[d*4 +: 4];
    a  = sram_ack[d*4 +: 4];
    case (ph[d])
      0: if (st) begin ph[d] = 1; ew[d][2] = 1; end
      1: begin ph[d] = 2; ew[d][3] = 1; end
      2: begin ph[d] = 3; cnt[d] = 0; end
      3: if (sta_pri[d] && sta_sec[d]) begin ph[d] = 4; ew[d][4] = 0; end
         else if (cnt[d] == T - 1) ph[d] = 9;
         else cnt[d]++;
      4: begin ph[d] = 5; ew[d][1] = 0; end
      5: begin ph[d] = 6; ew[d][0] = 1; end
      6: if (m != 0) begin ph[d] = 7; ew[d][11:8] = ew[d][11:8] & ~m; cnt[d] = 0; end
         else ph[d] = 8;
      7: if ((a & m) == 0) ph[d] = 8;
         else if (cnt[d] == T - 1) ph[d] = 9;
         else cnt[d]++;
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int d = 0; d < ND; d++) begin ph[d] = 0; cnt[d] = 0; ew[d] = 12'hF12; end
    end else begin
      for (int d = ND - 1; d >= 0; d--) model_step(d);
    end
    #4;
    for (int d = 0; d < ND; d++) begin
      vectors++;
      if (dom_ctrl[d*12 +: 12] !== ew[d] || dom_up[d] !== (ph[d] == 8) ||
          dom_fault[d] !== (ph[d] == 9)) begin
        fails++;
        $display("FAIL %s dom%0d: ctrl=%h up=%b flt=%b expected ctrl=%h up=%b flt=%b",
                 tag_for(ph[d]), d, dom_ctrl[d*12 +: 12], dom_up[d], dom_fault[d],
                 ew[d], ph[d] == 8, ph[d] == 9);
      end
    end
  end

  task automatic expect_val(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; seq_start = 0;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(1);
  endtask

  task automatic pulse_start();
    seq_start = 1;
    wait_cyc(1);
    seq_start = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  always @(posedge clk) if (cycles > 20000) begin
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 0; seq_start = 0;
    sta_pri = '1; sta_sec = '1; sram_mask = '0; sram_ack = '0;
    do_reset();
    // R1: reset state
    expect_val("R1 ctrl", dom_ctrl, {3{12'hF12}});
    expect_val("R1 flags", {dom_up, dom_fault, chain_up}, 0);

    // Scenario A: full chain, dom0 skips SRAM, dom1 all banks, dom2 two banks
    sram_mask = {4'h3, 4'hF, 4'h0};
    pulse_start();
    wait_cyc(40);
    expect_val("R10 chain up", chain_up, 1);
    expect_val("R6 dom0 pd kept", dom_ctrl[11:8], 4'hF);
    expect_val("R5 dom1 pd cleared", dom_ctrl[23:20], 4'h0);
    expect_val("R5 dom2 pd masked", dom_ctrl[35:32], 4'hC);
    pulse_start();
    wait_cyc(4);
    expect_val("R9 start after done", dom_ctrl[11:0], 12'hF0D);

    // Scenario B: dom1 secondary status missing -> fault, chain halts
    do_reset();
    sram_mask = '0; sta_sec = 3'b101;
    pulse_start();
    wait_cyc(3);
    pulse_start();  // R9: start while busy
    wait_cyc(50);
    expect_val("R7 dom1 fault", dom_fault, 3'b010);
    expect_val("R7 dom1 frozen", dom_ctrl[23:12], 12'hF1E);
    expect_val("R10 dom2 untouched", dom_ctrl[35:24], 12'hF12);

    // Scenario C: ack bits outside mask ignored; late ack clear
    do_reset();
    sta_sec = '1; sram_mask = {4'h3, 4'h0, 4'h0};
    sram_ack = {4'b0110, 4'hF, 4'h0};
    pulse_start();
    wait_cyc(28);
    expect_val("R5 dom2 waiting", dom_up, 3'b011);
    sram_ack = {4'b0100, 4'hF, 4'h0};
    wait_cyc(3);
    expect_val("R5 dom2 up", chain_up, 1);

    // Scenario D: late secondary status on dom0; dom2 ack never clears
    do_reset();
    sta_sec = 3'b110; sram_mask = {4'h3, 4'h0, 4'h0}; sram_ack = {4'h3, 4'h0, 4'h0};
    pulse_start();
    wait_cyc(12);
    expect_val("R3 dom0 waits for both", dom_ctrl[4], 1);
    sta_sec = '1;
    wait_cyc(60);
    expect_val("R7 dom2 ack fault", dom_fault, 3'b100);
    expect_val("R7 dom2 frozen", dom_ctrl[35:24], 12'hC0D);
    expect_val("R8 exclusive", dom_up & dom_fault, 0);

    summary();
  end
endmodule